// File: doc/BRIEF.md
# DRAM Bank Activation Timing Tracker

This block watches the command stream between a command scheduler and the command bus of a four-bank DDR mobile DRAM. In every cycle it gets one decoded command, a bank select and a row address. In the same cycle it reports whether that command may be issued now. It also keeps, for each bank, whether a row is open and which row that is. Three cycle counts, set on static configuration inputs, define the timing windows it enforces. Activate-to-access is tRCD. Activate-to-activate on one bank is tRC. Activate-to-activate across banks is tRRD.

Each bank has its own two-state controller. The states are `BK_CLOSED` and `BK_OPEN`. The transition *open* moves `BK_CLOSED` to `BK_OPEN` on a legal ACTIVE to that bank and captures the row. The transition *close* moves `BK_OPEN` to `BK_CLOSED` on a PRECHARGE to that bank. Any other command keeps the state (*hold*). Each bank has its own down-counters for tRCD and tRC. One shared down-counter covers tRRD and remembers which bank was activated last. When a command is illegal, a violation flag with a rule code appears for one cycle, on the cycle after that command. The tracker state does not change.

Top module: `bank_act_tracker`

## Requirements
- R1: After reset every bank is closed, every open-row field is zero, `viol_o` is low, and the first ACTIVE to any bank is legal at once.
- R2: A legal ACTIVE (command code 1) moves the addressed bank to open on the next cycle. Bank b's row appears in `open_row_o[b*13 +: 13]`.
- R3: A READ (code 2) or WRITE (code 3) to a closed bank is illegal with violation code 4.
- R4: A READ or WRITE to an open bank is illegal with code 5 until tRCD cycles after its ACTIVE. At ACTIVE cycle plus tRCD it is legal. A tRCD of 0 acts as 1.
- R5: An ACTIVE to a bank that is already open is illegal with code 1.
- R6: An ACTIVE to a closed bank is illegal with code 2 until tRC cycles after the previous ACTIVE to that same bank. A tRC of 0 acts as 1.
- R7: An ACTIVE to a bank other than the last activated one is illegal with code 3 until tRRD cycles after that last ACTIVE. A repeat ACTIVE to the same bank is not subject to tRRD.
- R8: A PRECHARGE (code 4) is always legal. It closes the addressed bank. On a closed bank it has no effect.
- R9: An illegal command sets `viol_o` for exactly the next cycle, with its code on `viol_code_o`. It leaves every bank state and row unchanged. A legal command gives `viol_o` low and code 0 on the next cycle.
- R10: When several rules fail at once, the reported code follows this priority. For ACTIVE: open bank (1), then tRC (2), then tRRD (3). For READ/WRITE: closed bank (4), then tRCD (5).
- R11: Command code 0 (NOP) and the unused codes 5 to 7 are always legal and change nothing.
- R12: Each timing count is sampled when its counter is loaded by an ACTIVE. Changing a configuration input later does not alter a window already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE |
| ba_i | input | 2 | Bank select |
| row_i | input | 13 | Row address, used by ACTIVE |
| cfg_trcd_i | input | 6 | Activate-to-access cycles |
| cfg_trrd_i | input | 6 | Cross-bank activate-to-activate cycles |
| cfg_trc_i | input | 6 | Same-bank activate-to-activate cycles |
| legal_o | output | 1 | Current command may be issued this cycle |
| viol_o | output | 1 | Previous cycle's command was illegal |
| viol_code_o | output | 3 | Rule broken by the previous command, 0 if none |
| bank_open_o | output | 4 | Per-bank open flag |
| open_row_o | output | 52 | Open row of each bank, bank b at bits b*13 upward |

## Verification
The hardest case to reach is an ACTIVE that breaks more than one rule in the same cycle. An example is a closed bank whose tRC window is still running while the tRRD window of a different bank is also running. Reaching it takes a precise sequence: activate bank 0 with a long tRC, precharge it, wait out tRRD, then activate bank 1. Re-activating bank 0 in the next cycle then hits both windows. The stimulus also reaches each window edge exactly, one cycle early and then on time. It also changes a configuration input while a window runs.

// File: rtl/bat_pkg.sv
package bat_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        VC_NONE     = 3'd0,
        VC_ROW_OPEN = 3'd1,
        VC_TRC      = 3'd2,
        VC_TRRD     = 3'd3,
        VC_NOT_OPEN = 3'd4,
        VC_TRCD     = 3'd5
    } vcode_e;

    typedef enum logic {
        BK_CLOSED = 1'b0,
        BK_OPEN   = 1'b1
    } bk_state_e;

endpackage

// File: rtl/bat_dncnt.sv
module bat_dncnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] cfg_i,
    output logic             busy_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // A window of N cycles ends N cycles after the load edge; 0 behaves as 1.
    always_comb begin
        load_val = (cfg_i == '0) ? '0 : cfg_i - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/bat_bank.sv
module bat_bank
    import bat_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [CNT_W-1:0] cfg_trcd_i,
    input  logic [CNT_W-1:0] cfg_trc_i,
    output logic             is_open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rcd_busy_o,
    output logic             rc_busy_o
);
    bk_state_e        state_q, state_d;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_CLOSED;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (act_i) begin
                row_q <= row_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_CLOSED: if (act_i) state_d = BK_OPEN;
            BK_OPEN:   if (pre_i) state_d = BK_CLOSED;
            default:   state_d = BK_CLOSED;
        endcase
    end

    always_comb begin
        is_open_o = 1'b0;
        unique case (state_q)
            BK_CLOSED: is_open_o = 1'b0;
            BK_OPEN:   is_open_o = 1'b1;
            default:   is_open_o = 1'b0;
        endcase
    end

    assign row_o = row_q;

    bat_dncnt #(.CNT_W(CNT_W)) u_rcd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (act_i),
        .cfg_i  (cfg_trcd_i),
        .busy_o (rcd_busy_o)
    );

    bat_dncnt #(.CNT_W(CNT_W)) u_rc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (act_i),
        .cfg_i  (cfg_trc_i),
        .busy_o (rc_busy_o)
    );
endmodule

// File: rtl/bank_act_tracker.sv
module bank_act_tracker
    import bat_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13,
    parameter int CNT_W = 6,
    localparam int NB   = 1 << BA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cmd_i,
    input  logic [BA_W-1:0]     ba_i,
    input  logic [ROW_W-1:0]    row_i,
    input  logic [CNT_W-1:0]    cfg_trcd_i,
    input  logic [CNT_W-1:0]    cfg_trrd_i,
    input  logic [CNT_W-1:0]    cfg_trc_i,
    output logic                legal_o,
    output logic                viol_o,
    output logic [2:0]          viol_code_o,
    output logic [NB-1:0]       bank_open_o,
    output logic [NB*ROW_W-1:0] open_row_o
);
    logic [NB-1:0] rcd_busy, rc_busy, act_vec, pre_vec;
    logic          rrd_busy;
    logic [BA_W-1:0] last_ba_q;
    vcode_e        code;
    logic          act_ok;
    logic          viol_q;
    logic [2:0]    code_q;

    // Rule evaluation with fixed priority per command
    always_comb begin
        code = VC_NONE;
        unique case (cmd_i)
            CMD_ACT: begin
                if (bank_open_o[ba_i])                    code = VC_ROW_OPEN;
                else if (rc_busy[ba_i])                   code = VC_TRC;
                else if (rrd_busy && (ba_i != last_ba_q)) code = VC_TRRD;
            end
            CMD_RD, CMD_WR: begin
                if (!bank_open_o[ba_i])                   code = VC_NOT_OPEN;
                else if (rcd_busy[ba_i])                  code = VC_TRCD;
            end
            default: code = VC_NONE;
        endcase
    end

    assign legal_o = (code == VC_NONE);
    assign act_ok  = (cmd_i == CMD_ACT) && legal_o;

    always_comb begin
        act_vec = '0;
        pre_vec = '0;
        act_vec[ba_i] = act_ok;
        pre_vec[ba_i] = (cmd_i == CMD_PRE);
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bat_bank #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act_vec[b]),
            .pre_i      (pre_vec[b]),
            .row_i      (row_i),
            .cfg_trcd_i (cfg_trcd_i),
            .cfg_trc_i  (cfg_trc_i),
            .is_open_o  (bank_open_o[b]),
            .row_o      (open_row_o[b*ROW_W +: ROW_W]),
            .rcd_busy_o (rcd_busy[b]),
            .rc_busy_o  (rc_busy[b])
        );
    end

    bat_dncnt #(.CNT_W(CNT_W)) u_rrd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (act_ok),
        .cfg_i  (cfg_trrd_i),
        .busy_o (rrd_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ba_q <= '0;
            viol_q    <= 1'b0;
            code_q    <= 3'd0;
        end else begin
            if (act_ok) begin
                last_ba_q <= ba_i;
            end
            viol_q <= !legal_o;
            code_q <= code;
        end
    end

    assign viol_o      = viol_q;
    assign viol_code_o = code_q;
endmodule

// File: rtl/bat_chk.sv
module bat_chk #(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13,
    parameter int CNT_W = 6,
    localparam int NB   = 1 << BA_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          cmd_i,
    input logic [BA_W-1:0]     ba_i,
    input logic [ROW_W-1:0]    row_i,
    input logic [CNT_W-1:0]    cfg_trc_i,
    input logic                legal_o,
    input logic                viol_o,
    input logic [2:0]          viol_code_o,
    input logic [NB-1:0]       bank_open_o,
    input logic [NB*ROW_W-1:0] open_row_o
);
    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && legal_o) |=> (bank_open_o[$past(ba_i)] &&
            open_row_o[$past(ba_i)*ROW_W +: ROW_W] == $past(row_i)));

    assert_closed_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == 3'd2 || cmd_i == 3'd3) && !bank_open_o[ba_i]) |-> !legal_o);

    assert_open_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && bank_open_o[ba_i]) |-> !legal_o);

    assert_trc_b2b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && legal_o && cfg_trc_i > 6'd1) |=>
            !(cmd_i == 3'd1 && ba_i == $past(ba_i) && legal_o));

    assert_pre_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd4) |-> legal_o);

    assert_pre_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd4) |=> !bank_open_o[$past(ba_i)]);

    assert_viol_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_o |=> (viol_o && viol_code_o != 3'd0));

    assert_no_viol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        legal_o |=> (!viol_o && viol_code_o == 3'd0));

    assert_hold_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_o |=> ($stable(bank_open_o) && $stable(open_row_o)));
endmodule

bind bank_act_tracker bat_chk #(.BA_W(BA_W), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .ba_i        (ba_i),
    .row_i       (row_i),
    .cfg_trc_i   (cfg_trc_i),
    .legal_o     (legal_o),
    .viol_o      (viol_o),
    .viol_code_o (viol_code_o),
    .bank_open_o (bank_open_o),
    .open_row_o  (open_row_o)
);

// File: tb/tb_bank_act_tracker.sv
module tb_bank_act_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    // {cmd[3], ba[2], row[13], legal[1], code[3], open mask after[4]} = 26 bits
    // table config: tRCD=3, tRRD=2, tRC=6
    localparam logic [25:0] VEC [0:NV-1] = '{
        {3'd1, 2'd0, 13'h0123, 1'b1, 3'd0, 4'b0001}, // c0  ACT b0        R2
        {3'd1, 2'd1, 13'h00AA, 1'b0, 3'd3, 4'b0001}, // c1  ACT b1 tRRD   R7
        {3'd2, 2'd0, 13'h0000, 1'b0, 3'd5, 4'b0001}, // c2  RD b0 tRCD   R4
        {3'd3, 2'd0, 13'h0000, 1'b1, 3'd0, 4'b0001}, // c3  WR b0 ok     R4
        {3'd1, 2'd1, 13'h00AA, 1'b1, 3'd0, 4'b0011}, // c4  ACT b1 ok    R7
        {3'd1, 2'd0, 13'h0BAD, 1'b0, 3'd1, 4'b0011}, // c5  ACT open b0  R5 R10
        {3'd4, 2'd0, 13'h0000, 1'b1, 3'd0, 4'b0010}, // c6  PRE b0       R8
        {3'd4, 2'd0, 13'h0000, 1'b1, 3'd0, 4'b0010}, // c7  PRE closed   R8
        {3'd2, 2'd2, 13'h0000, 1'b0, 3'd4, 4'b0010}, // c8  RD closed    R3
        {3'd2, 2'd1, 13'h0000, 1'b1, 3'd0, 4'b0010}, // c9  RD b1 ok     R4
        {3'd1, 2'd0, 13'h1FFF, 1'b1, 3'd0, 4'b0011}, // c10 ACT b0       R2
        {3'd4, 2'd0, 13'h0000, 1'b1, 3'd0, 4'b0010}, // c11 PRE b0       R8
        {3'd1, 2'd0, 13'h0001, 1'b0, 3'd2, 4'b0010}, // c12 ACT tRC      R6
        {3'd5, 2'd0, 13'h0002, 1'b1, 3'd0, 4'b0010}, // c13 unused code  R11
        {3'd0, 2'd0, 13'h0000, 1'b1, 3'd0, 4'b0010}, // c14 NOP          R11
        {3'd1, 2'd0, 13'h0003, 1'b0, 3'd2, 4'b0010}, // c15 ACT tRC edge R6
        {3'd1, 2'd0, 13'h0456, 1'b1, 3'd0, 4'b0011}, // c16 ACT at tRC   R6
        {3'd1, 2'd3, 13'h0777, 1'b0, 3'd3, 4'b0011}, // c17 ACT b3 tRRD  R7
        {3'd1, 2'd3, 13'h0777, 1'b1, 3'd0, 4'b1011}  // c18 ACT b3 ok    R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  ba = 2'd0;
    logic [12:0] row = 13'd0;
    logic [5:0]  cfg_trcd = 6'd3, cfg_trrd = 6'd2, cfg_trc = 6'd6;
    logic        legal, viol;
    logic [2:0]  viol_code;
    logic [3:0]  bank_open;
    logic [51:0] open_row;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_act_tracker dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .ba_i        (ba),
        .row_i       (row),
        .cfg_trcd_i  (cfg_trcd),
        .cfg_trrd_i  (cfg_trrd),
        .cfg_trc_i   (cfg_trc),
        .legal_o     (legal),
        .viol_o      (viol),
        .viol_code_o (viol_code),
        .bank_open_o (bank_open),
        .open_row_o  (open_row)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd = 3'd0; ba = 2'd0; row = 13'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [2:0] c, input logic [1:0] b, input logic [12:0] r,
                        input logic el, input logic [2:0] ec, input string tag);
        @(negedge clk);
        cmd = c; ba = b; row = r;
        #1;
        chk({tag, " legal"}, 64'(legal), 64'(el));
        @(posedge clk);
        #1;
        chk({tag, " viol"}, 64'(viol), 64'(!el));
        chk({tag, " code"}, 64'(viol_code), 64'(ec));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        chk("R1 open mask", 64'(bank_open), 64'h0);
        chk("R1 rows", 64'(open_row), 64'h0);
        chk("R1 viol", 64'(viol), 64'h0);
        chk("R1 nop legal", 64'(legal), 64'h1);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][25:23], VEC[i][22:21], VEC[i][20:8], VEC[i][7], VEC[i][6:4],
                 $sformatf("R9 vec%0d", i));
            chk($sformatf("R9 vec%0d mask", i), 64'(bank_open), 64'(VEC[i][3:0]));
        end
        chk("R2 row b0", 64'(open_row[0 +: 13]), 64'h0456);
        chk("R2 row b1", 64'(open_row[13 +: 13]), 64'h00AA);
        chk("R2 row b3", 64'(open_row[39 +: 13]), 64'h0777);
        chk("R2 row b2 closed", 64'(open_row[26 +: 13]), 64'h0);

        // R12: config change during a running tRCD window
        cfg_trcd = 6'd4; cfg_trrd = 6'd2; cfg_trc = 6'd6;
        do_reset();
        step(3'd1, 2'd2, 13'h0ABC, 1'b1, 3'd0, "R1 first act");
        cfg_trcd = 6'd1;
        step(3'd2, 2'd2, 13'h0, 1'b0, 3'd5, "R12 rd c1");
        step(3'd2, 2'd2, 13'h0, 1'b0, 3'd5, "R12 rd c2");
        step(3'd2, 2'd2, 13'h0, 1'b0, 3'd5, "R12 rd c3");
        step(3'd2, 2'd2, 13'h0, 1'b1, 3'd0, "R12 rd c4");

        // R4: tRCD of zero behaves as one
        cfg_trcd = 6'd0;
        do_reset();
        step(3'd1, 2'd1, 13'h0010, 1'b1, 3'd0, "R4 act");
        step(3'd3, 2'd1, 13'h0, 1'b1, 3'd0, "R4 wr next cycle");

        // R10: tRC takes priority over tRRD
        cfg_trcd = 6'd1; cfg_trrd = 6'd3; cfg_trc = 6'd8;
        do_reset();
        step(3'd1, 2'd0, 13'h0001, 1'b1, 3'd0, "R10 act b0");
        step(3'd4, 2'd0, 13'h0, 1'b1, 3'd0, "R8 pre b0");
        step(3'd0, 2'd0, 13'h0, 1'b1, 3'd0, "R11 nop");
        step(3'd1, 2'd1, 13'h0BEE, 1'b1, 3'd0, "R7 act b1 at tRRD");
        step(3'd1, 2'd0, 13'h0002, 1'b0, 3'd2, "R10 trc over trrd");
        step(3'd1, 2'd1, 13'h1111, 1'b0, 3'd1, "R5 act open b1");
        chk("R9 row kept", 64'(open_row[13 +: 13]), 64'h0BEE);
        chk("R9 mask kept", 64'(bank_open), 64'b0010);
        step(3'd3, 2'd2, 13'h0, 1'b0, 3'd4, "R10 closed first");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule